// File: doc/BRIEF.md
# Hitless Switch Phase Offset Corrector

This block sits in front of the phase detector of a digital phase-locked loop. It turns a reference phase count and a loop feedback phase count into the phase error that the loop filter sees. Both counts are modulo-N values over one reference period. When the mode controller signals that the loop is leaving holdover, or that a different reference has been selected, it pulses a capture strobe. The block then stores the present reference-to-feedback offset. From then on it subtracts that offset, so the loop sees a virtual reference whose phase matches the feedback. The switch therefore causes no phase step.

An active-low clear input removes the stored offset. After a clear, the error reported to the loop is the true, wrapped difference between reference and feedback. The error is always in the shortest-path signed range, so the loop pulls the output toward the reference along the least phase travel. The block does not ramp this step itself. It reports the full error, and the loop filter's bandwidth sets how fast alignment converges. If the clear input is held low all the time, no offset is kept and the outputs follow the selected reference directly.

Top module: `phase_offset_corrector`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `err_out` is 0 and the stored offset is 0.
- R2: Each rising edge registers `err_out = wrap((ref_phase - fb_phase - offset) mod PH_MOD)`. Here offset is the value the stored offset takes at that same edge, so `err_out` changes one cycle after its inputs are applied.
- R3: A rising edge with `capture` high, while clear is not active, stores `(ref_phase - fb_phase) mod PH_MOD` as the offset. The `err_out` registered at that edge is 0.
- R4: With `capture` low and clear not active, the stored offset holds its value. `err_out` then reports only the phase movement since the last capture.
- R5: `clr_n` passes through `CLR_SYNC` (default 2) synchronizer flops. A low level sampled at edge k sets the offset to 0 at edge k+CLR_SYNC, and `err_out` registered at that edge already uses offset 0.
- R6: While clear is active, a `capture` pulse stores 0 rather than the measured offset, so `err_out` equals `wrap((ref_phase - fb_phase) mod PH_MOD)`.
- R7: `wrap(x)` maps x in 0..PH_MOD-1 to the signed range -PH_MOD/2..PH_MOD/2-1. It subtracts PH_MOD when x >= PH_MOD/2. For example, with PH_MOD=1000, a difference of 500 gives -500 and a difference of 499 gives 499. This is the direction of least phase travel.
- R8: `ref_phase` and `fb_phase` are always below PH_MOD. `PH_MOD` is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_phase | input | PW | Selected reference phase count, 0..PH_MOD-1 |
| fb_phase | input | PW | Loop feedback phase count, 0..PH_MOD-1 |
| capture | input | 1 | Strobe from the mode controller: measure and store the offset |
| clr_n | input | 1 | Active-low offset clear, asynchronous to clk |
| err_out | output | PW+1 | Signed corrected phase error to the loop filter |

PW is `$clog2(PH_MOD)`.

## Verification
The assertions assume that both phase counts stay below PH_MOD in every cycle after reset. They also assume that `clr_n` is only ever sampled through the synchronizer. The properties on clear are written against the synchronized clear, not the raw pin. The stimulus draws phases with `$urandom % PH_MOD`, so it never leaves the legal range. It drives `clr_n` in runs of several cycles, so every clear spans enough edges to reach the offset register, and capture pulses land both inside and outside those runs.

// File: rtl/poc_pkg.sv
package poc_pkg;
  // What the offset register does at the next edge
  typedef enum logic [1:0] {
    OFS_HOLD = 2'd0,
    OFS_LOAD = 2'd1,
    OFS_ZERO = 2'd2
  } ofs_act_t;
endpackage

// File: rtl/poc_clr_sync.sv
module poc_clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  output logic clr_act
);
  generate
    if (STAGES == 0) begin : g_direct
      assign clr_act = ~clr_n;
    end else begin : g_sync
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[STAGES-2+((STAGES==1)?1:0):0], clr_n};
      end
      assign clr_act = ~sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/poc_mod_sub.sv
module poc_mod_sub #(
  parameter int MOD = 1000,
  localparam int W  = $clog2(MOD)
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] d
);
  localparam logic [W:0] MODX = (W+1)'(MOD);
  logic [W:0] ax, bx, t;
  always_comb begin
    ax = {1'b0, a};
    bx = {1'b0, b};
    if (ax >= bx) t = ax - bx;
    else          t = ax + MODX - bx;
    d = t[W-1:0];
  end
endmodule

// File: rtl/poc_wrap.sv
module poc_wrap #(
  parameter int MOD = 1000,
  localparam int W  = $clog2(MOD)
) (
  input  logic [W-1:0]        x,
  output logic signed [W:0]   y
);
  localparam logic [W-1:0] HALF = W'(MOD / 2);
  localparam logic signed [W:0] MODS = (W+1)'(MOD);
  always_comb begin
    if (x >= HALF) y = $signed({1'b0, x}) - MODS;
    else           y = $signed({1'b0, x});
  end
endmodule

// File: rtl/poc_offset_reg.sv
module poc_offset_reg
  import poc_pkg::*;
#(
  parameter int MOD = 1000,
  localparam int W  = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic         clr_act,
  input  logic [W-1:0] meas,
  output logic [W-1:0] ofs_next,
  output logic [W-1:0] ofs_q
);
  ofs_act_t act;

  always_comb begin
    if (clr_act)      act = OFS_ZERO;
    else if (capture) act = OFS_LOAD;
    else              act = OFS_HOLD;
    unique case (act)
      OFS_ZERO: ofs_next = '0;
      OFS_LOAD: ofs_next = meas;
      default:  ofs_next = ofs_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ofs_q <= '0;
    else     ofs_q <= ofs_next;
  end
endmodule

// File: rtl/phase_offset_corrector.sv
module phase_offset_corrector #(
  parameter int PH_MOD   = 1000,
  parameter int CLR_SYNC = 2,
  localparam int PW      = $clog2(PH_MOD)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PW-1:0]        ref_phase,
  input  logic [PW-1:0]        fb_phase,
  input  logic                 capture,
  input  logic                 clr_n,
  output logic signed [PW:0]   err_out
);
  logic          clr_act;
  logic [PW-1:0] raw_diff;
  logic [PW-1:0] ofs_next, ofs_q;
  logic [PW-1:0] corr_diff;
  logic signed [PW:0] corr_wrap;

  poc_clr_sync #(.STAGES(CLR_SYNC)) u_sync (
    .clk(clk), .rst(rst), .clr_n(clr_n), .clr_act(clr_act)
  );

  // raw reference-to-feedback offset
  poc_mod_sub #(.MOD(PH_MOD)) u_raw (
    .a(ref_phase), .b(fb_phase), .d(raw_diff)
  );

  poc_offset_reg #(.MOD(PH_MOD)) u_ofs (
    .clk(clk), .rst(rst), .capture(capture), .clr_act(clr_act),
    .meas(raw_diff), .ofs_next(ofs_next), .ofs_q(ofs_q)
  );

  // virtual reference: subtract the offset in force after this edge
  poc_mod_sub #(.MOD(PH_MOD)) u_corr (
    .a(raw_diff), .b(ofs_next), .d(corr_diff)
  );

  poc_wrap #(.MOD(PH_MOD)) u_wrap (
    .x(corr_diff), .y(corr_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) err_out <= '0;
    else     err_out <= corr_wrap;
  end
endmodule

// File: rtl/poc_checker.sv
module poc_checker #(
  parameter int MOD = 1000,
  localparam int W  = $clog2(MOD)
) (
  input logic                clk,
  input logic                rst,
  input logic [W-1:0]        ref_phase,
  input logic [W-1:0]        fb_phase,
  input logic                capture,
  input logic                clr_act,
  input logic [W-1:0]        ofs_q,
  input logic signed [W:0]   err_out
);
  localparam int LO = -(MOD / 2);
  localparam int HI = MOD - MOD / 2 - 1;

  // R1: reset clears both output and offset
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (err_out == 0 && ofs_q == '0));

  // R3: capture aligns the virtual reference
  a_r3_capture_zero: assert property (@(posedge clk) disable iff (rst)
    (capture && !clr_act) |=> (err_out == 0));

  // R4: offset holds without events
  a_r4_offset_hold: assert property (@(posedge clk) disable iff (rst)
    (!capture && !clr_act) |=> $stable(ofs_q));

  // R5 / R6: synchronized clear forces zero offset, capture or not
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> (ofs_q == '0));

  // R7: error stays in the shortest-path range
  a_r7_err_range: assert property (@(posedge clk) disable iff (rst)
    (int'(err_out) >= LO && int'(err_out) <= HI));

  // R8: input counts stay below the modulus
  a_r8_in_range: assert property (@(posedge clk) disable iff (rst)
    (int'(ref_phase) < MOD && int'(fb_phase) < MOD));
endmodule

bind phase_offset_corrector poc_checker #(.MOD(PH_MOD)) u_chk (
  .clk(clk), .rst(rst), .ref_phase(ref_phase), .fb_phase(fb_phase),
  .capture(capture), .clr_act(clr_act), .ofs_q(ofs_q), .err_out(err_out)
);

// File: tb/tb_phase_offset_corrector.sv
`timescale 1ns/1ps
module tb_phase_offset_corrector;
  localparam int N  = 1000;
  localparam int CS = 2;
  localparam int PW = $clog2(N);

  logic clk = 0;
  logic rst;
  logic [PW-1:0] ref_phase, fb_phase;
  logic capture, clr_n;
  logic signed [PW:0] err_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  int m_ofs;
  bit m_sync [CS];

  always #5 clk = ~clk;

  phase_offset_corrector #(.PH_MOD(N), .CLR_SYNC(CS)) dut (
    .clk(clk), .rst(rst), .ref_phase(ref_phase), .fb_phase(fb_phase),
    .capture(capture), .clr_n(clr_n), .err_out(err_out)
  );

  function automatic int mmod(int x);
    return ((x % N) + N) % N;
  endfunction

  function automatic int wrapv(int x);
    int d = mmod(x);
    if (d >= N / 2) d -= N;
    return d;
  endfunction

  task automatic check(int exp, string tag);
    n_chk++;
    if (int'(err_out) != exp) begin
      n_bad++;
      $display("FAIL %s: err_out actual %0d expected %0d", tag, int'(err_out), exp);
    end
  endtask

  // called at a negedge: drive, advance model across one posedge, check
  task automatic step(int r, int f, bit cap, bit cn, string tag);
    int raw, nofs, exp;
    bit clr_act;
    ref_phase = PW'(r);
    fb_phase  = PW'(f);
    capture   = cap;
    clr_n     = cn;
    clr_act = !m_sync[CS-1];
    raw = mmod(r - f);
    if (clr_act)  nofs = 0;
    else if (cap) nofs = raw;
    else          nofs = m_ofs;
    exp = wrapv(raw - nofs);
    m_ofs = nofs;
    for (int i = CS - 1; i > 0; i--) m_sync[i] = m_sync[i-1];
    m_sync[0] = cn;
    @(posedge clk);
    @(negedge clk);
    check(exp, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1; ref_phase = '0; fb_phase = '0; capture = 0; clr_n = 1;
    m_ofs = 0;
    for (int i = 0; i < CS; i++) m_sync[i] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(0, "R1 in reset");
    rst = 0;
    @(posedge clk); @(negedge clk);
    check(0, "R1 after release");

    // R2 plain difference
    step(300, 100, 0, 1, "R2 no offset");
    // R3 capture
    step(300, 100, 1, 1, "R3 capture gives zero");
    // R4 movement relative to captured alignment
    step(310, 100, 0, 1, "R4 +10 drift");
    step(100, 310, 0, 1, "R4 wrapped drift");
    // R7 boundaries with offset 200
    step(700, 0, 0, 1, "R7 half-period maps to -N/2");
    step(699, 0, 0, 1, "R7 just below half");
    step(0, 201, 0, 1, "R7 negative side");
    // R5 clear pulse, held for CS+1 cycles
    step(650, 50, 0, 0, "R5 clear sampled");
    step(650, 50, 0, 0, "R5 clear in sync");
    step(650, 50, 0, 0, "R5 clear takes effect");
    step(650, 50, 0, 1, "R5 offset gone, least-travel error");
    // R6 held clear: capture stores zero
    step(900, 100, 0, 0, "R6 clear held");
    step(900, 100, 0, 0, "R6 clear held");
    step(900, 100, 1, 0, "R6 capture while clear");
    step(20, 980, 1, 0, "R6 capture while clear 2");
    step(20, 980, 0, 0, "R6 tracks reference");
    step(20, 980, 0, 1, "R6 release");
    step(20, 980, 0, 1, "R6 release settled");
    step(20, 980, 1, 1, "R3 capture after release");

    // random mix
    begin
      int clr_run = 0;
      for (int k = 0; k < 3000; k++) begin
        bit cap, cn;
        if (clr_run == 0 && ($urandom % 40) == 0) clr_run = 2 + ($urandom % 6);
        cn = (clr_run == 0);
        if (clr_run > 0) clr_run--;
        cap = (($urandom % 12) == 0);
        step(int'($urandom % N), int'($urandom % N), cap, cn,
             cap ? "R3/R6 random capture" : "R2/R4 random");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule